// File: doc/BRIEF.md
# Compare and Bit Test Flag Unit

This block updates the status flags of an 8-bit processor for its two non-destructive test operations. Each operation works on an accumulator value and a memory operand. The compare operation performs an effective subtraction of the memory operand from the accumulator and throws the difference away. Only the zero, negative and carry flags take its result. The bit test performs an AND of the two operands for the zero flag. It also copies the two top bits of the memory operand straight into the negative and overflow flags.

The flags live in a register inside the unit. The register loads on a rising clock edge only while the update enable is high. A flag that the selected operation does not name keeps its old value. The accumulator is only an input here, so neither operation can change it. Operand fetch and addressing belong to the surrounding core.

Top module: `cbt_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four flag outputs become 0 at that edge.
- R2: When `upd_en` is low at a rising edge, no flag output changes at that edge.
- R3: A compare (`op_sel` = 0) with `upd_en` high sets `flag_z` to 1 when the accumulator equals the memory operand, and to 0 otherwise.
- R4: A compare sets `flag_n` to bit 7 of the 8-bit difference (accumulator − memory) mod 256.
- R5: A compare sets `flag_c` to 1 when the memory operand is less than or equal to the accumulator (unsigned), and to 0 when it is greater. An equal compare therefore gives 1.
- R6: A compare leaves `flag_v` at its previous value.
- R7: A bit test (`op_sel` = 1) with `upd_en` high sets `flag_n` to bit 7 and `flag_v` to bit 6 of the memory operand, whatever the accumulator holds.
- R8: A bit test sets `flag_z` to 1 when the bitwise AND of accumulator and memory operand is zero, and to 0 otherwise.
- R9: A bit test leaves `flag_c` at its previous value.
- R10: Flag outputs show the result of an update from the rising edge at which `upd_en` was sampled high, one register stage after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Loads the flag register at this edge |
| op_sel | input | 1 | 0 = compare, 1 = bit test |
| acc_in | input | 8 | Accumulator value (read only) |
| mem_in | input | 8 | Memory operand |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Two of the unit's functions can fall in the same cycle. The first pair is an equal compare, which must raise zero and carry together. The second pair is a bit test whose mask excludes the top memory bits, which must raise negative and overflow while zero is also set. Directed operands provoke both cases: equal values for the compare, and an accumulator of 0x00 with a memory operand of 0xC0 for the bit test. Random operations with random enables interleave with these. Every flag is judged against a bench model that carries the untouched flags forward from the previous cycle, so a flag that was disturbed when it should have held also shows up.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int DATA_W = 8;
    localparam int MSB    = DATA_W - 1;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic {
        OP_CMP  = 1'b0,
        OP_BTST = 1'b1
    } test_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, z: 1'b0, c: 1'b0};

    // Widened subtraction: the top bit is the borrow out.
    function automatic logic [DATA_W:0] wide_sub(input byte_t a, input byte_t b);
        return {1'b0, a} - {1'b0, b};
    endfunction

    function automatic logic is_zero(input byte_t x);
        return (x == '0);
    endfunction

endpackage

// File: rtl/cbt_cmp_eval.sv
module cbt_cmp_eval
    import cbt_pkg::*;
(
    input  byte_t  acc,
    input  byte_t  mem,
    input  flags_t prev,
    output flags_t next
);
    logic [DATA_W:0] diff_w;

    always_comb begin
        diff_w = wide_sub(acc, mem);
        next.n = diff_w[MSB];
        next.z = is_zero(diff_w[MSB:0]);
        next.c = ~diff_w[DATA_W];
        next.v = prev.v;
    end
endmodule

// File: rtl/cbt_bit_eval.sv
module cbt_bit_eval
    import cbt_pkg::*;
(
    input  byte_t  acc,
    input  byte_t  mem,
    input  flags_t prev,
    output flags_t next
);
    byte_t masked;

    always_comb begin
        masked = acc & mem;
        next.n = mem[MSB];
        next.v = mem[MSB-1];
        next.z = is_zero(masked);
        next.c = prev.c;
    end
endmodule

// File: rtl/cbt_flag_store.sv
module cbt_flag_store
    import cbt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= FLAGS_RESET;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/cbt_flag_unit.sv
module cbt_flag_unit
    import cbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_en,
    input  logic       op_sel,
    input  logic [7:0] acc_in,
    input  logic [7:0] mem_in,
    output logic       flag_n,
    output logic       flag_v,
    output logic       flag_z,
    output logic       flag_c
);
    test_op_e op;
    flags_t   cur;
    flags_t   cmp_next;
    flags_t   bit_next;
    flags_t   sel_next;

    assign op = test_op_e'(op_sel);

    cbt_cmp_eval u_cmp (
        .acc  (acc_in),
        .mem  (mem_in),
        .prev (cur),
        .next (cmp_next)
    );

    cbt_bit_eval u_bit (
        .acc  (acc_in),
        .mem  (mem_in),
        .prev (cur),
        .next (bit_next)
    );

    always_comb begin
        unique case (op)
            OP_CMP:  sel_next = cmp_next;
            OP_BTST: sel_next = bit_next;
            default: sel_next = cur;
        endcase
    end

    cbt_flag_store u_store (
        .clk  (clk),
        .rst  (rst),
        .load (upd_en),
        .d    (sel_next),
        .q    (cur)
    );

    assign flag_n = cur.n;
    assign flag_v = cur.v;
    assign flag_z = cur.z;
    assign flag_c = cur.c;
endmodule

// File: rtl/cbt_flag_unit_chk.sv
module cbt_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       upd_en,
    input logic       op_sel,
    input logic [7:0] acc_in,
    input logic [7:0] mem_in,
    input logic       flag_n,
    input logic       flag_v,
    input logic       flag_z,
    input logic       flag_c
);
    logic [3:0] fl;
    assign fl = {flag_n, flag_v, flag_z, flag_c};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (fl == 4'b0000)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(fl)); // R2

    AST_CMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !op_sel) |=> (flag_z == ($past(acc_in) == $past(mem_in)))); // R3

    AST_CMP_CARRY: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !op_sel) |=> (flag_c == ($past(mem_in) <= $past(acc_in)))); // R5

    AST_CMP_KEEP_V: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !op_sel) |=> $stable(flag_v)); // R6

    AST_BIT_TOP: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel) |=> (flag_n == $past(mem_in[7]) && flag_v == $past(mem_in[6]))); // R7

    AST_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel) |=> (flag_z == (($past(acc_in) & $past(mem_in)) == 8'h00))); // R8

    AST_BIT_KEEP_C: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel) |=> $stable(flag_c)); // R9
endmodule

bind cbt_flag_unit cbt_flag_unit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .upd_en (upd_en),
    .op_sel (op_sel),
    .acc_in (acc_in),
    .mem_in (mem_in),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .flag_z (flag_z),
    .flag_c (flag_c)
);

// File: tb/cbt_flag_unit_test.sv
`timescale 1ns/1ps
module cbt_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_en = 1'b0;
    logic       op_sel = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] mem_in = 8'h00;
    logic       flag_n, flag_v, flag_z, flag_c;

    int checks = 0;
    int failures = 0;
    logic [3:0] model = 4'b0000; // {n,v,z,c}
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    cbt_flag_unit uut (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op_sel(op_sel),
        .acc_in(acc_in), .mem_in(mem_in),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
    );

    function automatic logic [3:0] expect_flags(input logic op, input logic [7:0] a,
                                                input logic [7:0] m, input logic [3:0] p);
        logic [7:0] d;
        logic [3:0] r;
        if (!op) begin
            d = a - m;
            r = {d[7], p[2], (a == m), (m <= a)};
        end else begin
            r = {m[7], m[6], ((a & m) == 8'h00), p[0]};
        end
        return r;
    endfunction

    task automatic chk1(input string req, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s flag %s actual=%0b expected=%0b", req, name, act, exp);
        end
    endtask

    // Inputs are applied at a falling edge, the rising edge loads, the next falling edge samples.
    task automatic step(input logic en, input logic op, input logic [7:0] a, input logic [7:0] m);
        upd_en = en; op_sel = op; acc_in = a; mem_in = m;
        @(negedge clk);
        if (en) model = expect_flags(op, a, m, model);
        if (!en) begin
            chk1("R2", "N", flag_n, model[3]);
            chk1("R2", "V", flag_v, model[2]);
            chk1("R2", "Z", flag_z, model[1]);
            chk1("R2", "C", flag_c, model[0]);
        end else if (!op) begin
            chk1("R4", "N", flag_n, model[3]);
            chk1("R6", "V", flag_v, model[2]);
            chk1("R3", "Z", flag_z, model[1]);
            chk1("R5", "C", flag_c, model[0]);
        end else begin
            chk1("R7", "N", flag_n, model[3]);
            chk1("R7", "V", flag_v, model[2]);
            chk1("R8", "Z", flag_z, model[1]);
            chk1("R9", "C", flag_c, model[0]);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk1("R1", "NVZC", (flag_n | flag_v | flag_z | flag_c), 1'b0);
        rst = 1'b0;

        // Directed compare corners (R3 R4 R5 R10)
        step(1'b1, 1'b0, 8'h42, 8'h42); // equal: Z and C together
        step(1'b1, 1'b0, 8'h00, 8'hFF); // mem greater
        step(1'b1, 1'b0, 8'hFF, 8'h00);
        step(1'b1, 1'b0, 8'h80, 8'h01); // difference 0x7F
        step(1'b1, 1'b0, 8'h01, 8'h02); // difference 0xFF
        // Bit test with the mask excluding the top bits: N, V and Z together (R7 R8)
        step(1'b1, 1'b1, 8'h00, 8'hC0);
        step(1'b1, 1'b1, 8'h01, 8'h3F);
        step(1'b1, 1'b1, 8'hFF, 8'h00);
        // V set by the bit test must survive a compare (R6)
        step(1'b1, 1'b1, 8'h00, 8'h40);
        step(1'b1, 1'b0, 8'h10, 8'h20);
        // Idle cycles with changing inputs (R2)
        step(1'b0, 1'b1, 8'hAA, 8'h55);
        step(1'b0, 1'b0, 8'h00, 8'h00);

        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, $urandom % 2, 8'($urandom), 8'($urandom));
        end

        // Reset mid-run clears again (R1)
        rst = 1'b1;
        @(negedge clk);
        chk1("R1", "NVZC", (flag_n | flag_v | flag_z | flag_c), 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule